// File: doc/BRIEF.md
# Frame Sync Protection and Insertion

This block sits behind the sync-pattern detector of an optical-disc read channel. It keeps a free-running frame timer clocked by the channel-bit enable and uses it to predict where the next frame sync should land. A raw sync pulse is trusted only when it falls close enough to that prediction. When no trusted sync shows up, the timer supplies a synthetic one, so downstream logic always sees one frame strobe per frame.

A run of synthetic frames longer than a programmable limit marks the channel as unlocked. While unlocked the acceptance window is ignored, and the first raw sync re-anchors the timer. Next to the per-frame lock flag, a slow LOCK status samples that flag on every sixteenth frame strobe. The status rises on a single good sample and falls only after eight bad samples in a row, which makes it suitable for switching a spindle servo between phase and speed control.

Top module: `fsync_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `frame_stb`, `lock_flag` and `lock_out` are 0 and `unlock_flag` is 1.
- R2: The frame timer advances only on cycles with `bit_en` high, and `sync_det` has no effect on cycles with `bit_en` low. The nominal sync falls FRAME_LEN enabled cycles after the previous frame strobe decision. After an insertion it falls FRAME_LEN enabled cycles after the previous nominal position.
- R3: While `unlock_flag` is 0, a `sync_det` on an enabled cycle whose offset from the nominal position is within the window half-width is accepted. `frame_stb` is high in the next cycle, and the timer realigns to that cycle.
- R4: The window half-width is 3 enabled cycles when `win_wide` is 0 and 7 when it is 1. Both bounds are inclusive, on the early side and on the late side.
- R5: While `unlock_flag` is 0, a `sync_det` outside the window produces no frame strobe.
- R6: If no sync is accepted by the window's late bound (nominal + half-width), a synthetic strobe is issued for that enabled cycle, and `lock_flag` becomes 0.
- R7: `lock_flag` is updated with each frame strobe and holds between strobes. It is 1 only when the accepted sync fell exactly on the nominal position.
- R8: `unlock_flag` rises when the count of consecutive insertions reaches the limit chosen by `unlock_sel`: code 0 gives 2, code 1 gives 4, code 2 gives 8 and code 3 gives 13.
- R9: While `unlock_flag` is 1, any enabled `sync_det` is accepted regardless of window. Acceptance clears `unlock_flag` and the insertion count.
- R10: A high `ins_clr` sets the insertion count to zero and leaves `unlock_flag` unchanged.
- R11: `lock_out` changes only with a frame strobe. On every sixteenth strobe since reset it samples the strobe's lock result and rises if that sample is 1.
- R12: `lock_out` falls only after eight consecutive sampled lock results of 0.
- R13: `frame_stb` is a single-cycle pulse in the cycle after the deciding enabled edge. `lock_flag`, `unlock_flag` and `lock_out` change in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Channel-bit clock enable |
| sync_det | input | 1 | Raw frame sync detected, qualified by bit_en |
| win_wide | input | 1 | Window half-width select: 0 = 3, 1 = 7 |
| unlock_sel | input | 2 | Insertion count for unlock: 2, 4, 8, 13 |
| ins_clr | input | 1 | Synchronous clear of the insertion count |
| frame_stb | output | 1 | Protected frame strobe |
| lock_flag | output | 1 | Last frame's sync fell exactly on nominal |
| unlock_flag | output | 1 | Insertion limit reached, window bypassed |
| lock_out | output | 1 | Filtered lock status |

## Verification
Syncs are placed at the nominal position, at each inclusive window bound, one cycle beyond each bound, and not at all, for both window widths. This separates acceptance, off-position acceptance and insertion, and also shows the late bound winning over insertion. Runs of silent frames under every limit code show the exact frame on which unlock rises, and a far-early sync then proves the window is bypassed. Long stretches of inserted frames after on-time frames show the filtered status rising on one sample and holding through seven bad samples.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  localparam int INS_W = 4;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_ACCEPT = 2'd1,
    EV_INSERT = 2'd2
  } frame_ev_e;

  // Consecutive insertions that declare loss of lock.
  function automatic logic [INS_W-1:0] unlock_limit(input logic [1:0] code);
    case (code)
      2'd0:    unlock_limit = INS_W'(2);
      2'd1:    unlock_limit = INS_W'(4);
      2'd2:    unlock_limit = INS_W'(8);
      default: unlock_limit = INS_W'(13);
    endcase
  endfunction

  // Saturating increment of the insertion count.
  function automatic logic [INS_W-1:0] sat_inc(input logic [INS_W-1:0] v);
    sat_inc = (v == {INS_W{1'b1}}) ? v : v + 1'b1;
  endfunction

endpackage

// File: rtl/fsg_frame_timer.sv
module fsg_frame_timer
  import fsg_pkg::*;
#(
  parameter int FRAME_LEN  = 588,
  parameter int WIN_NARROW = 3,
  parameter int WIN_WIDE   = 7,
  localparam int CW        = $clog2(FRAME_LEN + WIN_WIDE + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_en,
  input  logic      sync_det,
  input  logic      win_wide,
  input  logic      unlocked,
  output frame_ev_e ev,
  output logic      on_nominal,
  output logic      in_window
);

  localparam logic [CW-1:0] NOM_C = CW'(FRAME_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half;
  logic [CW-1:0] win_lo;
  logic [CW-1:0] win_hi;
  logic          win_close;
  logic          take;
  logic          synth;

  always_comb begin
    half       = win_wide ? CW'(WIN_WIDE) : CW'(WIN_NARROW);
    win_lo     = NOM_C - half;
    win_hi     = NOM_C + half;
    in_window  = (cnt_q >= win_lo) && (cnt_q <= win_hi);
    on_nominal = (cnt_q == NOM_C);
    win_close  = (cnt_q >= win_hi);
    take       = bit_en && sync_det && (unlocked || in_window);
    synth      = bit_en && !take && win_close;
    if (take)       ev = EV_ACCEPT;
    else if (synth) ev = EV_INSERT;
    else            ev = EV_NONE;
  end

  // An insertion is issued half-width cycles after nominal, so the
  // count resumes at half to keep the next nominal position in place.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (take)   cnt_q <= '0;
    else if (synth)  cnt_q <= half;
    else if (bit_en) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/fsg_insert_track.sv
module fsg_insert_track
  import fsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  frame_ev_e  ev,
  input  logic       ins_clr,
  input  logic [1:0] unlock_sel,
  output logic       unlock_flag
);

  logic [INS_W-1:0] ins_q;
  logic [INS_W:0]   ins_next_w;
  logic             limit_hit;

  always_comb begin
    ins_next_w = {1'b0, ins_q} + 1'b1;
    limit_hit  = ins_next_w >= {1'b0, unlock_limit(unlock_sel)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q       <= '0;
      unlock_flag <= 1'b1;
    end else if (ev == EV_ACCEPT) begin
      ins_q       <= '0;
      unlock_flag <= 1'b0;
    end else if (ins_clr) begin
      ins_q       <= '0;
    end else if (ev == EV_INSERT) begin
      ins_q <= sat_inc(ins_q);
      if (limit_hit) unlock_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/fsg_lock_filter.sv
module fsg_lock_filter #(
  parameter int SAMPLE_EVERY = 16,
  parameter int LOW_RUN      = 8,
  localparam int SCW         = $clog2(SAMPLE_EVERY),
  localparam int LRW         = $clog2(LOW_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic sample_val,
  output logic lock_out
);

  localparam logic [SCW-1:0] LAST_C = SCW'(SAMPLE_EVERY - 1);
  localparam logic [LRW-1:0] RUN_C  = LRW'(LOW_RUN);

  logic [SCW-1:0] stb_q;
  logic [LRW-1:0] low_q;
  logic [LRW:0]   low_inc;
  logic           sample_now;

  always_comb begin
    low_inc    = {1'b0, low_q} + 1'b1;
    sample_now = strobe && (stb_q == LAST_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q    <= '0;
      low_q    <= '0;
      lock_out <= 1'b0;
    end else begin
      if (strobe) stb_q <= (stb_q == LAST_C) ? '0 : stb_q + 1'b1;
      if (sample_now) begin
        if (sample_val) begin
          lock_out <= 1'b1;
          low_q    <= '0;
        end else begin
          if (low_q != RUN_C) low_q <= low_q + 1'b1;
          if (low_inc >= {1'b0, RUN_C}) lock_out <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/fsync_guard.sv
module fsync_guard
  import fsg_pkg::*;
#(
  parameter int FRAME_LEN    = 588,
  parameter int WIN_NARROW   = 3,
  parameter int WIN_WIDE     = 7,
  parameter int SAMPLE_EVERY = 16,
  parameter int LOW_RUN      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       sync_det,
  input  logic       win_wide,
  input  logic [1:0] unlock_sel,
  input  logic       ins_clr,
  output logic       frame_stb,
  output logic       lock_flag,
  output logic       unlock_flag,
  output logic       lock_out
);

  frame_ev_e ev;
  logic      on_nominal;
  logic      in_window;
  logic      accept_ev;
  logic      insert_ev;
  logic      strobe_ev;
  logic      exact_ev;

  fsg_frame_timer #(
    .FRAME_LEN (FRAME_LEN),
    .WIN_NARROW(WIN_NARROW),
    .WIN_WIDE  (WIN_WIDE)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .sync_det  (sync_det),
    .win_wide  (win_wide),
    .unlocked  (unlock_flag),
    .ev        (ev),
    .on_nominal(on_nominal),
    .in_window (in_window)
  );

  assign accept_ev = (ev == EV_ACCEPT);
  assign insert_ev = (ev == EV_INSERT);
  assign strobe_ev = accept_ev || insert_ev;
  assign exact_ev  = accept_ev && on_nominal;

  fsg_insert_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev),
    .ins_clr    (ins_clr),
    .unlock_sel (unlock_sel),
    .unlock_flag(unlock_flag)
  );

  fsg_lock_filter #(
    .SAMPLE_EVERY(SAMPLE_EVERY),
    .LOW_RUN     (LOW_RUN)
  ) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe_ev),
    .sample_val(exact_ev),
    .lock_out  (lock_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_stb <= 1'b0;
      lock_flag <= 1'b0;
    end else begin
      frame_stb <= strobe_ev;
      if (strobe_ev) lock_flag <= exact_ev;
    end
  end

endmodule

// File: rtl/fsync_guard_chk.sv
module fsync_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic frame_stb,
  input logic lock_flag,
  input logic unlock_flag,
  input logic lock_out,
  input logic accept_ev,
  input logic insert_ev,
  input logic on_nominal,
  input logic in_window
);

  // R13
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb);

  // R2
  stb_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> !frame_stb);

  // R6
  insert_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insert_ev |=> (frame_stb && !lock_flag));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |-> $stable(lock_flag));

  // R7
  nominal_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && on_nominal) |=> lock_flag);

  // R5
  window_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && !unlock_flag) |-> in_window);

  // R8
  unlock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock_flag) |-> (frame_stb && !lock_flag));

  // R9
  unlock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlock_flag) |-> frame_stb);

  // R11
  lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |-> $stable(lock_out));

endmodule

bind fsync_guard fsync_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .frame_stb  (frame_stb),
  .lock_flag  (lock_flag),
  .unlock_flag(unlock_flag),
  .lock_out   (lock_out),
  .accept_ev  (accept_ev),
  .insert_ev  (insert_ev),
  .on_nominal (on_nominal),
  .in_window  (in_window)
);

// File: tb/tb_fsync_guard.sv
module tb_fsync_guard;

  localparam int CLK_PERIOD = 10;
  localparam int FL         = 40;
  localparam int WD_LIMIT   = 150000;

  typedef struct packed {
    logic              send;
    logic              wide;
    logic signed [7:0] delta;
    logic              acc;
    logic              lk;
    logic              ul;
  } vec_t;

  // Sync offset from nominal, window select, expected accept/lock/unlock.
  localparam vec_t VECS [0:12] = '{
    '{1'b1, 1'b0,   8'sd0, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b0,   8'sd2, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0,  -8'sd3, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0,  -8'sd4, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0,   8'sd0, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b1,  -8'sd7, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1,   8'sd7, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1,  -8'sd8, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1,   8'sd0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0,   8'sd0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0,   8'sd0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b0, -8'sd15, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0,   8'sd0, 1'b1, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       sync_det = 1'b0;
  logic       win_wide = 1'b0;
  logic [1:0] unlock_sel = 2'd1;
  logic       ins_clr = 1'b0;
  logic       frame_stb, lock_flag, unlock_flag, lock_out;

  int checks = 0;
  int fails = 0;
  int tick = 0;
  int nom = FL;
  int m_stb = 0;
  int m_low = 0;
  bit m_lock_out = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsync_guard #(.FRAME_LEN(FL)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_det(sync_det),
    .win_wide(win_wide), .unlock_sel(unlock_sel), .ins_clr(ins_clr),
    .frame_stb(frame_stb), .lock_flag(lock_flag),
    .unlock_flag(unlock_flag), .lock_out(lock_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic step();
    @(posedge clk);
    tick++;
    @(negedge clk);
  endtask

  function automatic int limit_of(input int code);
    case (code)
      0: return 2;
      1: return 4;
      2: return 8;
      default: return 13;
    endcase
  endfunction

  task automatic do_frame(input bit send, input int delta, input bit wide,
                          input bit exp_acc, input bit exp_lock,
                          input bit exp_unlock, input string req);
    int w;
    int target;
    int exp_t;
    bit early;
    w = wide ? 7 : 3;
    win_wide = wide;
    bit_en = 1'b1;
    target = nom + delta;
    exp_t = exp_acc ? target : nom + w;
    early = 1'b0;
    while (tick < exp_t) begin
      sync_det = send && (tick + 1 == target);
      step();
      sync_det = 1'b0;
      if (tick < exp_t && frame_stb) early = 1'b1;
    end
    chk(!early, req, "strobe ahead of expected cycle", int'(early), 0);
    chk(frame_stb == 1'b1, req, "frame strobe", int'(frame_stb), 1);
    chk(lock_flag == exp_lock, "R7", "lock flag", int'(lock_flag), int'(exp_lock));
    chk(unlock_flag == exp_unlock, "R8", "unlock flag", int'(unlock_flag), int'(exp_unlock));
    m_stb++;
    if (m_stb % 16 == 0) begin
      if (exp_lock) begin
        m_lock_out = 1'b1;
        m_low = 0;
      end else begin
        if (m_low < 8) m_low++;
        if (m_low >= 8) m_lock_out = 1'b0;
      end
    end
    chk(lock_out == m_lock_out, "R11", "filtered lock", int'(lock_out), int'(m_lock_out));
    nom = exp_acc ? target + FL : nom + FL;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R13 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    string tag;
    int lim;
    bit bad;
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(frame_stb == 0, "R1", "strobe in reset", int'(frame_stb), 0);
    chk(lock_flag == 0, "R1", "lock flag in reset", int'(lock_flag), 0);
    chk(unlock_flag == 1, "R1", "unlock flag in reset", int'(unlock_flag), 1);
    chk(lock_out == 0, "R1", "filtered lock in reset", int'(lock_out), 0);
    rst_n = 1'b1;
    step();
    tick = 0;
    nom = FL - 1;
    chk(unlock_flag == 1 && frame_stb == 0, "R1", "state after release",
        int'(unlock_flag), 1);

    // R9: unlocked after reset, far-off sync is taken
    do_frame(1'b1, -30, 1'b0, 1'b1, 1'b0, 1'b0, "R9");

    unlock_sel = 2'd1;
    for (int i = 0; i < 13; i++) begin
      if (VECS[i].ul || (i > 0 && VECS[i-1].ul)) tag = "R9";
      else if (!VECS[i].acc && VECS[i].send) tag = "R5";
      else if (!VECS[i].acc) tag = "R6";
      else if (VECS[i].delta == 0) tag = "R3";
      else tag = "R4";
      do_frame(VECS[i].send, int'(VECS[i].delta), VECS[i].wide,
               VECS[i].acc, VECS[i].lk, VECS[i].ul, tag);
    end

    // R8 every limit code
    for (int code = 0; code < 4; code++) begin
      unlock_sel = 2'(code);
      lim = limit_of(code);
      do_frame(1'b1, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
      for (int k = 1; k <= lim; k++)
        do_frame(1'b0, 0, 1'b0, 1'b0, 1'b0, (k >= lim), "R8");
      do_frame(1'b1, -20, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
    end

    // R10 clear of the insertion count
    unlock_sel = 2'd1;
    do_frame(1'b1, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    for (int k = 0; k < 3; k++) do_frame(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    ins_clr = 1'b1;
    step();
    ins_clr = 1'b0;
    for (int k = 1; k <= 4; k++)
      do_frame(1'b0, 0, 1'b0, 1'b0, 1'b0, (k == 4), "R10");
    ins_clr = 1'b1;
    step();
    ins_clr = 1'b0;
    chk(unlock_flag == 1, "R10", "unlock kept by clear", int'(unlock_flag), 1);
    do_frame(1'b1, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R9");

    // R2 disabled cycles freeze the timer and mask sync
    bad = 1'b0;
    bit_en = 1'b0;
    sync_det = 1'b1;
    repeat (25) begin
      @(posedge clk);
      @(negedge clk);
      if (frame_stb) bad = 1'b1;
    end
    sync_det = 1'b0;
    chk(!bad, "R2", "strobe while disabled", int'(bad), 0);
    do_frame(1'b1, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R2");

    // R11 rise on a good sample
    unlock_sel = 2'd3;
    for (int k = 0; k < 32 && !m_lock_out; k++)
      do_frame(1'b1, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R11");
    chk(lock_out == 1, "R11", "filtered lock up", int'(lock_out), 1);
    // R12 hold through seven bad samples, fall on the eighth
    for (int k = 1; m_low < 7 && k < 200; k++)
      do_frame(1'b0, 0, 1'b0, 1'b0, 1'b0, (k >= 13), "R12");
    chk(lock_out == 1, "R12", "held after seven low samples", int'(lock_out), 1);
    for (int k = 0; m_low < 8 && k < 20; k++)
      do_frame(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1, "R12");
    chk(lock_out == 0, "R12", "dropped after eight low samples", int'(lock_out), 0);
    for (int k = 0; k < 32 && !m_lock_out; k++)
      do_frame(1'b1, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R11");
    chk(lock_out == 1, "R11", "filtered lock regained", int'(lock_out), 1);

    // R1 reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk(unlock_flag == 1 && lock_out == 0 && lock_flag == 0 && frame_stb == 0,
        "R1", "mid-run reset", int'(unlock_flag), 1);
    summary();
    $finish;
  end

endmodule